// File: doc/BRIEF.md
# VLIW Bundle Extraction Buffer

This block sits between the instruction cache and the decode stage of a four-issue VLIW core. Every accepted fetch carries a 128-bit word of four 32-bit syllables, which are appended to an eight-syllable buffer. Each cycle the block looks at the head of the buffer and finds the first syllable whose end-of-bundle bit is set. That syllable and the ones before it form one variable-length bundle, which is handed to decode on lanes that start at lane 0. Because bundles are delimited only by that bit, no no-op padding is stored, and a bundle may begin in one fetch word and end in the next.

The block also checks each delivered bundle. It flags a bundle whose mix of operation classes exceeds the machine's issue resources, and a bundle whose cluster-start markings are wrong for a single-cluster machine. If four buffered syllables contain no end marker, the block reports an overlong bundle and drops those four syllables. A flush empties the buffer at once and loads a start offset, so the first word fetched after a redirect can enter part-way through.

Top module: `vliw_bundle_aligner`

## Requirements
- R1: After reset the buffer is empty: `fetch_ready` is 1, and `bundle_valid`, `lane_valid`, `illegal_bundle`, `cluster_err` and `overlong_err` are 0.
- R2: `fetch_ready` is 1 exactly when `flush` is low and the buffer holds at most 4 syllables. A word is taken on a rising edge where `fetch_valid` and `fetch_ready` are both 1. Syllable 0 of the word is bits 31:0, syllable 1 is bits 63:32, and so on.
- R3: In each syllable, bit 31 marks the last syllable of a bundle. When a marker appears in buffered positions 0 to 3, `bundle_valid` is 1 in that same cycle. The bundle is every syllable up to and including the first marker, and it is removed from the buffer on the next rising edge.
- R4: Bundle syllable i appears on lane i (`lane_syl` bits 32i+31:32i) with `lane_valid[i]` set. Lanes beyond the bundle have `lane_valid` clear and read zero.
- R5: A bundle may start in one fetch word and end in a later one. It is delivered once its final syllable has been buffered.
- R6: If the buffer holds at least four syllables and none of the first four carries the end marker, `overlong_err` is 1 and `bundle_valid` is 0. Those four syllables are discarded on the next rising edge.
- R7: While `flush` is 1, `bundle_valid`, `overlong_err` and `fetch_ready` are 0. On the next edge the buffer is emptied and no word is taken.
- R8: `start_ofs` is captured during a flush. The next word accepted after the flush contributes only its syllables from position `start_ofs` to 3. Later words are taken whole.
- R9: Bits 29:28 give the operation class: 00 integer, 01 multiply, 10 load/store, 11 branch. `illegal_bundle` is 1 with a valid bundle that has more than 4 integer, 2 multiply, 1 load/store or 1 branch syllables.
- R10: Bit 30 is the cluster-start bit. `cluster_err` is 1 with a valid bundle whose first syllable has bit 30 clear, or whose later syllables have any bit 30 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Redirect: empty the buffer |
| start_ofs | input | 2 | Entry position within the first word after a flush |
| fetch_valid | input | 1 | Fetch word present |
| fetch_ready | output | 1 | Buffer can take a word |
| fetch_word | input | 128 | Four syllables, syllable 0 in the low bits |
| bundle_valid | output | 1 | A bundle is presented this cycle |
| lane_valid | output | 4 | Per-lane occupancy of the bundle |
| lane_syl | output | 128 | Aligned syllables, lane 0 in the low bits |
| illegal_bundle | output | 1 | Bundle exceeds issue resources |
| cluster_err | output | 1 | Cluster-start bits wrong for the bundle |
| overlong_err | output | 1 | No end marker in four syllables; they are dropped |

## Verification
The extraction is driven with words of four single-syllable bundles, one full four-wide bundle, and bundles that cross a word boundary. Together these tell apart a correct realignment to lane 0 from one that keeps word positions or assumes the word is the bundle. Back-to-back two-syllable bundles fill the buffer and test the stall rule. A marker-free word separates the overlong drop from a silent hang. Flushes with each start offset, plus a long random stream with random stalls and rare flushes, are compared every cycle against a queue model that expects the same lanes and flags.

// File: rtl/bundle_pkg.sv
package bundle_pkg;
  localparam int SYL_W = 32;

  typedef enum logic [1:0] {
    OP_INT = 2'b00,
    OP_MUL = 2'b01,
    OP_LS  = 2'b10,
    OP_BR  = 2'b11
  } op_class_e;

  typedef struct packed {
    logic        stop;
    logic        cs;
    op_class_e   cls;
    logic [27:0] body;
  } syl_t;
endpackage

// File: rtl/syl_buffer.sv
module syl_buffer
  import bundle_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LANES = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int OW = $clog2(LANES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic [CW-1:0]          pop_cnt,
  input  logic                   push,
  input  logic [LANES*SYL_W-1:0] word,
  input  logic [OW-1:0]          start_ofs,
  output syl_t                   slot [DEPTH],
  output logic [CW-1:0]          cnt,
  output logic [OW-1:0]          pend_ofs
);
  syl_t          slot_q [DEPTH];
  syl_t          slot_d [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic [OW-1:0] pend_q, pend_d;
  logic          upd_en;
  int            rem_n;
  int            src_n;
  int            dst_n;

  always_comb begin
    slot_d = slot_q;
    cnt_d  = cnt_q;
    pend_d = pend_q;
    rem_n  = 0;
    src_n  = 0;
    dst_n  = 0;
    if (flush) begin
      cnt_d  = '0;
      pend_d = start_ofs;
    end else begin
      rem_n = int'(cnt_q) - int'(pop_cnt);
      for (int i = 0; i < DEPTH; i++) begin
        src_n = i + int'(pop_cnt);
        slot_d[i] = (src_n < DEPTH) ? slot_q[src_n] : '0;
      end
      cnt_d = CW'(rem_n);
      if (push) begin
        for (int j = 0; j < LANES; j++) begin
          dst_n = rem_n + j - int'(pend_q);
          if (j >= int'(pend_q) && dst_n < DEPTH)
            slot_d[dst_n] = syl_t'(word[j*SYL_W +: SYL_W]);
        end
        cnt_d  = CW'(rem_n + LANES - int'(pend_q));
        pend_d = '0;
      end
    end
  end

  assign upd_en = flush | push | (pop_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
    end
  end

  assign slot     = slot_q;
  assign cnt      = cnt_q;
  assign pend_ofs = pend_q;

  a_r8_offset_used_once: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush) |=> (pend_q == '0));
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));
endmodule

// File: rtl/bundle_scan.sv
module bundle_scan #(
  parameter int DEPTH = 8,
  parameter int LANES = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [LANES-1:0] stop_vec,
  input  logic [CW-1:0]    cnt,
  output logic             bundle_valid,
  output logic             overlong,
  output logic [LANES-1:0] lane_valid,
  output logic [CW-1:0]    pop_cnt
);
  logic          found;
  logic [CW-1:0] len;

  always_comb begin
    found = 1'b0;
    len   = '0;
    for (int i = 0; i < LANES; i++) begin
      if (!found && (i < int'(cnt)) && stop_vec[i]) begin
        found = 1'b1;
        len   = CW'(i + 1);
      end
    end
  end

  assign bundle_valid = found & ~flush;
  assign overlong     = ~found & ~flush & (int'(cnt) >= LANES);
  assign pop_cnt      = bundle_valid ? len : (overlong ? CW'(LANES) : '0);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_valid[g] = bundle_valid && (g < int'(len));
  end

  a_r4_lanes_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({1'b0, lane_valid} + 1'b1));
  a_r3_ends_on_marker: assert property (@(posedge clk) disable iff (!rst_n)
    bundle_valid |-> (stop_vec & lane_valid) != '0);
  a_r6_excludes_bundle: assert property (@(posedge clk) disable iff (!rst_n)
    overlong |-> !bundle_valid && (lane_valid == '0));
endmodule

// File: rtl/bundle_rules.sv
module bundle_rules #(
  parameter int LANES   = 4,
  parameter int MAX_INT = 4,
  parameter int MAX_MUL = 2,
  parameter int MAX_LS  = 1,
  parameter int MAX_BR  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bundle_valid,
  input  logic [LANES-1:0] lane_valid,
  input  logic [1:0]       cls [LANES],
  input  logic [LANES-1:0] cs_vec,
  output logic             illegal_bundle,
  output logic             cluster_err
);
  int   n_int, n_mul, n_ls, n_br;
  logic cs_late;

  always_comb begin
    n_int   = 0;
    n_mul   = 0;
    n_ls    = 0;
    n_br    = 0;
    cs_late = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_valid[i]) begin
        case (cls[i])
          2'b00:   n_int++;
          2'b01:   n_mul++;
          2'b10:   n_ls++;
          default: n_br++;
        endcase
        if (i > 0 && cs_vec[i]) cs_late = 1'b1;
      end
    end
  end

  assign illegal_bundle = bundle_valid &&
    (n_int > MAX_INT || n_mul > MAX_MUL || n_ls > MAX_LS || n_br > MAX_BR);
  assign cluster_err = bundle_valid && (!cs_vec[0] || cs_late);

  a_r9_flag_needs_bundle: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_bundle || cluster_err) |-> bundle_valid);
endmodule

// File: rtl/vliw_bundle_aligner.sv
module vliw_bundle_aligner
  import bundle_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int OW = $clog2(LANES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic [OW-1:0]          start_ofs,
  input  logic                   fetch_valid,
  output logic                   fetch_ready,
  input  logic [LANES*SYL_W-1:0] fetch_word,
  output logic                   bundle_valid,
  output logic [LANES-1:0]       lane_valid,
  output logic [LANES*SYL_W-1:0] lane_syl,
  output logic                   illegal_bundle,
  output logic                   cluster_err,
  output logic                   overlong_err
);
  logic [1:0]       rs_q;
  logic             rst_ok;
  syl_t             slot [DEPTH];
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    pop_cnt;
  logic [OW-1:0]    pend_ofs;
  logic             push;
  logic [LANES-1:0] stop_vec;
  logic [LANES-1:0] cs_vec;
  logic [1:0]       cls [LANES];

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ok = rs_q[1];

  assign fetch_ready = rst_ok && !flush && (int'(cnt) <= DEPTH - LANES);
  assign push        = fetch_valid && fetch_ready;

  syl_buffer #(.DEPTH(DEPTH), .LANES(LANES)) u_buf (
    .clk(clk), .rst_n(rst_ok), .flush(flush), .pop_cnt(pop_cnt),
    .push(push), .word(fetch_word), .start_ofs(start_ofs),
    .slot(slot), .cnt(cnt), .pend_ofs(pend_ofs)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_head
    assign stop_vec[g] = slot[g].stop;
    assign cs_vec[g]   = slot[g].cs;
    assign cls[g]      = slot[g].cls;
    assign lane_syl[g*SYL_W +: SYL_W] = lane_valid[g] ? slot[g] : '0;
  end

  bundle_scan #(.DEPTH(DEPTH), .LANES(LANES)) u_scan (
    .clk(clk), .rst_n(rst_ok), .flush(flush), .stop_vec(stop_vec),
    .cnt(cnt), .bundle_valid(bundle_valid), .overlong(overlong_err),
    .lane_valid(lane_valid), .pop_cnt(pop_cnt)
  );

  bundle_rules #(.LANES(LANES)) u_rules (
    .clk(clk), .rst_n(rst_ok), .bundle_valid(bundle_valid),
    .lane_valid(lane_valid), .cls(cls), .cs_vec(cs_vec),
    .illegal_bundle(illegal_bundle), .cluster_err(cluster_err)
  );

  a_r6_overlong_drops_four: assert property (@(posedge clk) disable iff (!rst_ok)
    (overlong_err && !push) |=> (cnt == $past(cnt) - CW'(LANES)));
  a_r2_stall_holds_level: assert property (@(posedge clk) disable iff (!rst_ok)
    (!push && !flush && pop_cnt == '0) |=> (cnt == $past(cnt)));
  a_r8_partial_entry: assert property (@(posedge clk) disable iff (!rst_ok)
    (push && pop_cnt == '0 && !flush) |=>
      (cnt == $past(cnt) + CW'(LANES) - CW'($past(pend_ofs))));
endmodule

// File: tb/vliw_bundle_aligner_bench.sv
module vliw_bundle_aligner_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         flush;
  logic [1:0]   start_ofs;
  logic         fetch_valid;
  logic         fetch_ready;
  logic [127:0] fetch_word;
  logic         bundle_valid;
  logic [3:0]   lane_valid;
  logic [127:0] lane_syl;
  logic         illegal_bundle;
  logic         cluster_err;
  logic         overlong_err;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [31:0] mq[$];
  int          mpend = 0;

  always #10 clk = ~clk;

  vliw_bundle_aligner u_vliw_bundle_aligner (
    .clk(clk), .rst_n(rst_n), .flush(flush), .start_ofs(start_ofs),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_word(fetch_word),
    .bundle_valid(bundle_valid), .lane_valid(lane_valid), .lane_syl(lane_syl),
    .illegal_bundle(illegal_bundle), .cluster_err(cluster_err),
    .overlong_err(overlong_err)
  );

  task automatic check(input bit ok, input string req, input string ph,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s [%s] actual=%h expected=%h", req, ph, act, exp);
    end
  endtask

  function automatic logic [31:0] syl(input bit stop, input bit cs,
                                      input logic [1:0] cls, input int tag);
    return {stop, cs, cls, 28'(tag)};
  endfunction

  function automatic logic [127:0] wd(input logic [31:0] s0, input logic [31:0] s1,
                                      input logic [31:0] s2, input logic [31:0] s3);
    return {s3, s2, s1, s0};
  endfunction

  // one cycle: drive, compare against the queue model, advance the model
  task automatic step(input bit fv, input logic [127:0] w, input bit fl,
                      input int ofs, input string ph);
    bit found;
    int len;
    bit e_rdy, e_bv, e_ov, e_ill, e_cl;
    logic [3:0] e_lv;
    logic [127:0] e_syl;
    int nm, nl, nb, ni;
    @(negedge clk);
    fetch_valid = fv; fetch_word = w; flush = fl; start_ofs = 2'(ofs);
    #1;
    e_rdy = !fl && (mq.size() <= 4);
    found = 0; len = 0;
    for (int i = 0; i < 4; i++)
      if (!found && i < mq.size() && mq[i][31]) begin found = 1; len = i + 1; end
    e_bv = found && !fl;
    e_ov = !found && !fl && (mq.size() >= 4);
    e_lv = '0; e_syl = '0; nm = 0; nl = 0; nb = 0; ni = 0; e_cl = 0;
    if (e_bv) begin
      for (int i = 0; i < len; i++) begin
        e_lv[i] = 1'b1;
        e_syl[i*32 +: 32] = mq[i];
        case (mq[i][29:28])
          2'b00: ni++;
          2'b01: nm++;
          2'b10: nl++;
          default: nb++;
        endcase
        if (i > 0 && mq[i][30]) e_cl = 1;
      end
      if (!mq[0][30]) e_cl = 1;
    end
    e_ill = e_bv && (ni > 4 || nm > 2 || nl > 1 || nb > 1);
    check(fetch_ready === e_rdy, "R2", ph, 128'(fetch_ready), 128'(e_rdy));
    check(bundle_valid === e_bv && lane_valid === e_lv, "R3", ph,
          {bundle_valid, lane_valid}, {e_bv, e_lv});
    check(lane_syl === e_syl, "R4", ph, lane_syl, e_syl);
    check(overlong_err === e_ov, "R6", ph, 128'(overlong_err), 128'(e_ov));
    check(illegal_bundle === e_ill, "R9", ph, 128'(illegal_bundle), 128'(e_ill));
    check(cluster_err === e_cl, "R10", ph, 128'(cluster_err), 128'(e_cl));
    if (fl) begin
      mq.delete();
      mpend = ofs;
    end else begin
      if (e_bv) for (int i = 0; i < len; i++) void'(mq.pop_front());
      else if (e_ov) for (int i = 0; i < 4; i++) void'(mq.pop_front());
      if (fv && e_rdy) begin
        for (int j = mpend; j < 4; j++) mq.push_back(w[j*32 +: 32]);
        mpend = 0;
      end
    end
  endtask

  task automatic idle(input int n, input string ph);
    for (int k = 0; k < n; k++) step(0, '0, 0, 0, ph);
  endtask

  initial begin
    rst_n = 1'b0; flush = 0; start_ofs = 0; fetch_valid = 0; fetch_word = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(fetch_ready === 1'b1 && bundle_valid === 1'b0 && lane_valid === 4'b0 &&
          illegal_bundle === 1'b0 && cluster_err === 1'b0 && overlong_err === 1'b0,
          "R1", "reset", {fetch_ready, bundle_valid, lane_valid, illegal_bundle,
          cluster_err, overlong_err}, 128'b1000000000);

    // single-syllable bundles
    step(1, wd(syl(1,1,0,1), syl(1,1,1,2), syl(1,1,2,3), syl(1,1,3,4)), 0, 0, "R3 singles");
    idle(5, "R3 singles");
    // one full four-wide bundle
    step(1, wd(syl(0,1,0,5), syl(0,0,1,6), syl(0,0,2,7), syl(1,0,3,8)), 0, 0, "R3 full");
    idle(3, "R3 full");
    // R5: bundles crossing a word boundary
    step(1, wd(syl(1,1,0,9), syl(0,1,0,10), syl(0,0,1,11), syl(0,0,0,12)), 0, 0, "R5 straddle");
    step(1, wd(syl(1,0,0,13), syl(0,1,2,14), syl(0,0,0,15), syl(0,0,0,16)), 0, 0, "R5 straddle");
    step(1, wd(syl(1,0,3,17), syl(1,1,0,18), syl(0,1,0,19), syl(1,0,1,20)), 0, 0, "R5 straddle");
    idle(5, "R5 straddle");
    // R2: two-syllable bundles fill the buffer and stall fetch
    for (int k = 0; k < 6; k++)
      step(1, wd(syl(0,1,0,21), syl(1,0,0,22), syl(0,1,1,23), syl(1,0,2,24)), 0, 0, "R2 fill");
    idle(8, "R2 fill");
    // R6: no end marker in four syllables
    step(1, wd(syl(0,1,0,30), syl(0,0,0,31), syl(0,0,0,32), syl(0,0,0,33)), 0, 0, "R6 overlong");
    idle(3, "R6 overlong");
    // R9: resource limits
    step(1, wd(syl(0,1,1,40), syl(0,0,1,41), syl(1,0,1,42), syl(0,1,2,43)), 0, 0, "R9 limits");
    step(1, wd(syl(1,0,2,44), syl(0,1,3,45), syl(1,0,3,46), syl(1,1,0,47)), 0, 0, "R9 limits");
    idle(5, "R9 limits");
    // R10: cluster-start placement
    step(1, wd(syl(1,0,0,50), syl(0,1,0,51), syl(1,1,0,52), syl(1,1,0,53)), 0, 0, "R10 cluster");
    idle(5, "R10 cluster");
    // R7 and R8: flush mid-stream, then partial entry at each offset
    for (int o = 0; o < 4; o++) begin
      step(1, wd(syl(0,1,0,60), syl(0,0,0,61), syl(0,0,0,62), syl(0,0,0,63)), 0, 0, "R7 flush");
      step(1, wd(syl(1,1,0,64), syl(1,1,0,65), syl(1,1,0,66), syl(1,1,0,67)), 1, o, "R7 flush");
      step(1, wd(syl(1,1,0,70), syl(1,1,1,71), syl(0,1,2,72), syl(1,0,3,73)), 0, 0, "R8 offset");
      step(1, wd(syl(1,1,0,74), syl(1,1,0,75), syl(1,1,0,76), syl(1,1,0,77)), 0, 0, "R8 offset");
      idle(6, "R8 offset");
    end
    // random stream
    for (int k = 0; k < 3000; k++) begin
      logic [127:0] w;
      for (int j = 0; j < 4; j++) begin
        int r;
        r = int'($urandom_range(0, 99));
        w[j*32 +: 32] = syl(r < 45, r > 20, 2'($urandom_range(0, 3)), k * 4 + j);
      end
      step($urandom_range(0, 3) != 0, w, $urandom_range(0, 40) == 0,
           int'($urandom_range(0, 3)), "random");
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule